// File: doc/BRIEF.md
# Host Interrupt Status Controller

This block gathers up to sixteen interrupt sources from a device and presents them to a host processor as one level-sensitive interrupt line. Each source is edge-detected. A rising edge sets a sticky pending bit, which stays set until the host clears it. A mask register decides which pending bits may raise the host line. A mask bit of 1 blocks its source, and a mask bit of 0 lets it through.

The host reaches the block through a small synchronous register bus. The mask can be written as a whole word. It also has two write-only aliases, one that sets bits and one that clears bits, so no read-modify-write is needed. Pending status can be read in two ways: a peek view that leaves it unchanged, and a clear-on-read view that empties it. A write-one acknowledge register retires chosen pending bits.

Source positions keep their meaning end to end: source input bit i is status bit i and mask bit i. In the intended use these are:
- bit 0: receive buffer A data
- bit 1: transmit data
- bit 2: transmit transfer
- bit 3: receive buffer B data
- bit 4: receive transfer
- bits 5 and 6: event mailbox
- bit 7: wake
- bits 8 and 9: trace
- bit 10: command done
- bit 14: initialisation done

Top module: `host_irq_status`

## Requirements
- R1: After reset, the mask reads 0x0001, the pending status reads 0, and `hostIrq` is low.
- R2: A 0-to-1 change on `srcIn[i]` sets pending bit i, which stays set while the source is held or dropped. A source held high sets the bit only once, and sets it again only after it goes low and then high.
- R3: `hostIrq` is high exactly one clock after some bit of (pending AND NOT mask) is 1.
- R4: A write to word address 0 loads the whole mask.
- R5: A write to word address 1 sets each mask bit written as 1 and leaves the other mask bits unchanged.
- R6: A write to word address 2 clears each mask bit written as 1 and leaves the other mask bits unchanged.
- R7: A read of word address 3 returns the pending bits and leaves them unchanged.
- R8: A read of word address 4 returns the pending bits and then clears all of them.
- R9: A write to word address 5 clears each pending bit written as 1. Bits written as 0 keep their pending state.
- R10: A rising source edge in the same cycle as a clear-on-read or an acknowledge of that bit leaves the bit set.
- R11: `rdData` is valid one clock after `rdEn`. Reads of address 0 return the mask. Reads of addresses 1, 2, 5, unmapped addresses, and cycles with no read return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Register word address |
| wrEn | input | 1 | Write strobe |
| wrData | input | NSRC | Write data |
| rdEn | input | 1 | Read strobe |
| rdData | output | NSRC | Registered read data |
| srcIn | input | NSRC | Device interrupt sources |
| hostIrq | output | 1 | Level interrupt to the host, active high |

## Verification
The assertions assume that the bus never presents a write and a read in the same cycle. Under that assumption, at most one register action is decoded per clock, and the mask-alias checks can compare against the written word alone. The bench keeps every bus access to its own single-cycle task, so reads and writes never overlap. Source edges are the only stimulus allowed to coincide with a bus access, and they are used that way only in the collision scenarios.

// File: rtl/hisc_pkg.sv
package hisc_pkg;
  localparam int OFF_MASK   = 0;
  localparam int OFF_MSET   = 1;
  localparam int OFF_MCLR   = 2;
  localparam int OFF_PEEK   = 3;
  localparam int OFF_RDCLR  = 4;
  localparam int OFF_ACK    = 5;

  typedef struct packed {
    logic maskWr;
    logic maskSet;
    logic maskClr;
    logic ackWr;
    logic corRd;
  } strobes_t;
endpackage

// File: rtl/hisc_ctrl.sv
module hisc_ctrl
  import hisc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int NSRC   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [NSRC-1:0]   maskQ,
  input  logic [NSRC-1:0]   pendQ,
  output strobes_t          strb,
  output logic [NSRC-1:0]   rdData
);
  logic hitMask, hitSet, hitClr, hitPeek, hitRdClr, hitAck;
  logic [NSRC-1:0] rdMux;

  assign hitMask  = (addr == ADDR_W'(OFF_MASK));
  assign hitSet   = (addr == ADDR_W'(OFF_MSET));
  assign hitClr   = (addr == ADDR_W'(OFF_MCLR));
  assign hitPeek  = (addr == ADDR_W'(OFF_PEEK));
  assign hitRdClr = (addr == ADDR_W'(OFF_RDCLR));
  assign hitAck   = (addr == ADDR_W'(OFF_ACK));

  always_comb begin
    strb.maskWr  = wrEn & hitMask;
    strb.maskSet = wrEn & hitSet;
    strb.maskClr = wrEn & hitClr;
    strb.ackWr   = wrEn & hitAck;
    strb.corRd   = rdEn & hitRdClr;
  end

  always_comb begin
    rdMux = '0;
    if (hitMask)              rdMux = maskQ;
    else if (hitPeek || hitRdClr) rdMux = pendQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN)     rdData <= '0;
    else if (rdEn) rdData <= rdMux;
    else           rdData <= '0;
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && rdEn) |-> $onehot0(strb)); // R11
  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (!rdEn || hitSet || hitClr || hitAck) |=> rdData == '0); // R11
endmodule

// File: rtl/hisc_datapath.sv
module hisc_datapath
  import hisc_pkg::*;
#(
  parameter int NSRC = 16,
  parameter logic [NSRC-1:0] MASK_RST = NSRC'(1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobes_t        strb,
  input  logic [NSRC-1:0] wrData,
  input  logic [NSRC-1:0] srcIn,
  output logic [NSRC-1:0] maskQ,
  output logic [NSRC-1:0] pendQ,
  output logic            hostIrq
);
  logic [NSRC-1:0] srcPrev;
  logic [NSRC-1:0] riseVec;
  logic [NSRC-1:0] clrVec;

  always_ff @(posedge clk) begin
    if (!rstN) srcPrev <= '0;
    else       srcPrev <= srcIn;
  end

  assign riseVec = srcIn & ~srcPrev;
  assign clrVec  = {NSRC{strb.corRd}} | (strb.ackWr ? wrData : '0);

  for (genvar i = 0; i < NSRC; i++) begin : g_pend
    always_ff @(posedge clk) begin
      if (!rstN)           pendQ[i] <= 1'b0;
      else if (riseVec[i]) pendQ[i] <= 1'b1;
      else if (clrVec[i])  pendQ[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             maskQ <= MASK_RST;
    else if (strb.maskWr)  maskQ <= wrData;
    else if (strb.maskSet) maskQ <= maskQ | wrData;
    else if (strb.maskClr) maskQ <= maskQ & ~wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) hostIrq <= 1'b0;
    else       hostIrq <= |(pendQ & ~maskQ);
  end

  AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (riseVec != '0) |=> ((pendQ & $past(riseVec)) == $past(riseVec))); // R10
  AST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.corRd && !strb.ackWr) |=> ((pendQ & $past(pendQ)) == $past(pendQ))); // R2
  AST_COR_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    strb.corRd |=> ((pendQ & ~$past(riseVec)) == '0)); // R8
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strb.ackWr |=> ((pendQ & $past(wrData) & ~$past(riseVec)) == '0)); // R9
  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rstN)
    strb.maskSet |=> (maskQ == ($past(maskQ) | $past(wrData)))); // R5
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rstN)
    strb.maskClr |=> (maskQ == ($past(maskQ) & ~$past(wrData)))); // R6
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ((pendQ & ~maskQ) == '0) |=> !hostIrq); // R3
endmodule

// File: rtl/host_irq_status.sv
module host_irq_status
  import hisc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int NSRC   = 16,
  parameter logic [NSRC-1:0] MASK_RST = NSRC'(1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [NSRC-1:0]   wrData,
  input  logic              rdEn,
  output logic [NSRC-1:0]   rdData,
  input  logic [NSRC-1:0]   srcIn,
  output logic              hostIrq
);
  strobes_t        strb;
  logic [NSRC-1:0] maskQ;
  logic [NSRC-1:0] pendQ;

  hisc_ctrl #(.ADDR_W(ADDR_W), .NSRC(NSRC)) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .maskQ(maskQ), .pendQ(pendQ), .strb(strb), .rdData(rdData)
  );

  hisc_datapath #(.NSRC(NSRC), .MASK_RST(MASK_RST)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .srcIn(srcIn),
    .maskQ(maskQ), .pendQ(pendQ), .hostIrq(hostIrq)
  );
endmodule

// File: tb/sim_host_irq_status.sv
module sim_host_irq_status;
  logic        clk = 0;
  logic        rstN = 0;
  logic [3:0]  addr = '0;
  logic        wrEn = 0;
  logic [15:0] wrData = '0;
  logic        rdEn = 0;
  logic [15:0] rdData;
  logic [15:0] srcIn = '0;
  logic        hostIrq;
  int nChk = 0, nFail = 0;

  always #10 clk = ~clk;

  host_irq_status u0 (.clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .rdEn(rdEn), .rdData(rdData), .srcIn(srcIn), .hostIrq(hostIrq));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [15:0] d);
    addr = a; wrData = d; wrEn = 1;
    @(negedge clk);
    wrEn = 0; wrData = '0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [15:0] d);
    addr = a; rdEn = 1;
    @(negedge clk);
    rdEn = 0;
    d = rdData;
  endtask

  task automatic pulseSrc(input logic [15:0] s);
    srcIn = srcIn | s;
    @(negedge clk);
    srcIn = srcIn & ~s;
    @(negedge clk);
  endtask

  task automatic testReset();
    logic [15:0] v;
    busRead(4'd0, v); chk("R1 mask", v, 16'h0001);
    busRead(4'd3, v); chk("R1 status", v, 16'h0000);
    chk("R1 irq", {15'd0, hostIrq}, 16'h0000);
  endtask

  task automatic testMaskedSource();
    logic [15:0] v;
    pulseSrc(16'h0001);
    chk("R3 masked src0 irq", {15'd0, hostIrq}, 16'h0000);
    busRead(4'd3, v); chk("R2 src0 pending", v, 16'h0001);
    busRead(4'd4, v); chk("R8 cor returns", v, 16'h0001);
    busRead(4'd3, v); chk("R8 cleared", v, 16'h0000);
  endtask

  task automatic testIrqAndPeek();
    logic [15:0] v;
    srcIn = 16'h0400;
    @(negedge clk);
    chk("R3 irq not yet", {15'd0, hostIrq}, 16'h0000);
    @(negedge clk);
    chk("R3 irq one clock later", {15'd0, hostIrq}, 16'h0001);
    busRead(4'd3, v); chk("R7 peek", v, 16'h0400);
    busRead(4'd3, v); chk("R7 peek unchanged", v, 16'h0400);
    busWrite(4'd5, 16'h0400);
    busRead(4'd3, v); chk("R2 held src no reset", v, 16'h0000);
    srcIn = 16'h0000; @(negedge clk);
    srcIn = 16'h0400; @(negedge clk);
    srcIn = 16'h0000;
    busRead(4'd3, v); chk("R2 re-edge sets", v, 16'h0400);
    busWrite(4'd5, 16'h0400);
    @(negedge clk);
    chk("R3 irq drops", {15'd0, hostIrq}, 16'h0000);
  endtask

  task automatic testMaskWrites();
    logic [15:0] v;
    busWrite(4'd0, 16'hA5A5);
    busRead(4'd0, v); chk("R4 full write", v, 16'hA5A5);
    busWrite(4'd1, 16'h0F00);
    busRead(4'd0, v); chk("R5 set alias", v, 16'hAFA5);
    busWrite(4'd2, 16'h00F0);
    busRead(4'd0, v); chk("R6 clear alias", v, 16'hAF05);
    busWrite(4'd1, 16'h0000);
    busRead(4'd0, v); chk("R5 zero no effect", v, 16'hAF05);
    busWrite(4'd2, 16'h0000);
    busRead(4'd0, v); chk("R6 zero no effect", v, 16'hAF05);
    pulseSrc(16'h0100);
    chk("R3 masked bit8", {15'd0, hostIrq}, 16'h0000);
    busWrite(4'd2, 16'h0100);
    @(negedge clk);
    chk("R3 unmask raises", {15'd0, hostIrq}, 16'h0001);
    busWrite(4'd0, 16'h0000);
    busRead(4'd4, v); chk("R8 cor bit8", v, 16'h0100);
  endtask

  task automatic testAck();
    logic [15:0] v;
    pulseSrc(16'h40FF);
    busWrite(4'd5, 16'h000F);
    busRead(4'd3, v); chk("R9 ack partial", v, 16'h40F0);
    busWrite(4'd5, 16'h0000);
    busRead(4'd3, v); chk("R9 zero ack no effect", v, 16'h40F0);
    busRead(4'd4, v); chk("R8 cor multi", v, 16'h40F0);
  endtask

  task automatic testCollisions();
    logic [15:0] v;
    pulseSrc(16'h0002);
    addr = 4'd4; rdEn = 1; srcIn = 16'h0008;
    @(negedge clk);
    rdEn = 0; srcIn = '0; v = rdData;
    chk("R10 cor value", v, 16'h0002);
    busRead(4'd3, v); chk("R10 edge beats cor", v, 16'h0008);
    addr = 4'd5; wrData = 16'h0008; wrEn = 1; srcIn = 16'h0008;
    @(negedge clk);
    wrEn = 0; wrData = '0; srcIn = '0;
    busRead(4'd3, v); chk("R10 edge beats ack", v, 16'h0008);
    busWrite(4'd5, 16'hFFFF);
  endtask

  task automatic testReadMap();
    logic [15:0] v;
    pulseSrc(16'h0020);
    busRead(4'd1, v); chk("R11 set alias reads 0", v, 16'h0000);
    busRead(4'd2, v); chk("R11 clr alias reads 0", v, 16'h0000);
    busRead(4'd5, v); chk("R11 ack reads 0", v, 16'h0000);
    busRead(4'd9, v); chk("R11 unmapped reads 0", v, 16'h0000);
    chk("R11 idle rdData", rdData, 16'h0000);
    busRead(4'd3, v); chk("R11 pending intact", v, 16'h0020);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rstN = 1;
        @(negedge clk);
        testReset();
        testMaskedSource();
        testIrqAndPeek();
        testMaskWrites();
        testAck();
        testCollisions();
        testReadMap();
      end
      begin
        repeat (5000) @(negedge clk);
        nChk++; nFail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule